// File: doc/BRIEF.md
# External Interrupt Request Flag Register

This block collects interrupt requests from six active-low external pins and shows them to software as one byte-wide flag register. Each pin is first passed through a two-flop synchronizer. A static per-pin mode input picks how the pin is sensed.

In edge mode, a high-to-low transition on the pin sets a sticky flag. The flag stays set, and keeps requesting an interrupt, until software clears it. Clearing follows a strict protocol: software must first read the flag as 1, then write 0 to that bit. Writing 1 to any bit changes nothing, so one flag can be cleared by writing 0 to it and 1 to all the others.

In level mode, the flag bit simply shows the inverted synchronized pin, and writes to it have no effect. A registered OR of all six flag views drives a single interrupt request line toward the interrupt controller.

Top module: `ext_irq_flags`

## Requirements
- R1: After reset, with all pins held high, every bit of `bus_rdata_o` reads 0 and `irq_o` is 0.
- R2: Bits 7 and 6 of `bus_rdata_o` always read 0, including after a write of 0xFF.
- R3: In edge mode (`sense_edge_i[i]`=1), a high-to-low transition on `pin_n_i[i]` sets flag bit i. The flag then stays 1 after the pin returns high.
- R4: Writing 1 to a flag bit leaves it unchanged.
- R5: Writing 0 to bit i clears an edge-mode flag only if a read returned 1 in bit i since the previous write. Any write discards all such read records.
- R6: A write with 0 in bit i and 1 in the other bits clears only flag i and leaves the other set flags at 1.
- R7: If a falling edge is detected on pin i in the same cycle as a valid clear of flag i, the flag stays 1.
- R8: In level mode (`sense_edge_i[i]`=0), bit i reads 1 exactly while the synchronized pin is low, and writes to bit i have no effect.
- R9: `irq_o` is the OR of the six flag views, registered, so it changes one cycle after the flags change.
- R10: A pin transition reaches the flag view after two clock edges of synchronization. An edge-mode flag therefore reads 1 after the third rising edge following the pin fall. A level-mode bit reads 1 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_n_i | input | 6 | Active-low external request pins, asynchronous |
| sense_edge_i | input | 6 | Per-pin sense mode: 1 = falling edge, 0 = low level |
| bus_sel_i | input | 1 | Register access strobe for the current cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read when selected |
| bus_wdata_i | input | 8 | Write data; bit i = 0 requests a clear of flag i |
| bus_rdata_o | output | 8 | Flag register view; bits 7 and 6 are 0 |
| irq_o | output | 1 | Registered OR of all flag views |

## Verification
A pin driven low just before a rising edge shows up as follows:
- a level-mode bit reads 1 after the second edge;
- an edge-mode flag reads 1 after the third edge;
- `irq_o` follows one edge after the flag view.

A write or read strobe takes effect at the single edge it is held across, so a clear is visible right after that edge while `irq_o` drops one edge later. Inputs change at falling clock edges and results are sampled there, after exactly the counted number of rising edges. The set-versus-clear race is staged by lowering the pin two edges before the write, so that detection lands on the write's edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Per-pin state held by one flag cell
    typedef struct packed {
        logic flag;     // sticky edge request
        logic marker;   // flag was read as one since last write
        logic prev;     // previous synchronized pin level
    } cell_state_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10
    } access_e;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int NUM_PINS = 6,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_n_i,
    output logic [NUM_PINS-1:0] sync_n_o
);

    typedef struct packed {
        logic [STAGES-1:0][NUM_PINS-1:0] stage;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.stage[0] = pin_n_i;
        for (int s = 1; s < STAGES; s++) begin
            state_d.stage[s] = state_q.stage[s-1];
        end
    end

    // Idle level of the active-low pins is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_n_o = state_q.stage[STAGES-1];

endmodule

// File: rtl/ext_irq_cell.sv
module ext_irq_cell
    import ext_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sync_n_i,
    input  logic    edge_mode_i,
    input  access_e access_i,
    input  logic    wbit_i,
    output logic    view_o,
    output logic    flag_o
);

    cell_state_t state_d, state_q;
    logic        fall;
    logic        clear_ok;

    always_comb begin
        state_d      = state_q;
        fall         = state_q.prev & ~sync_n_i;
        clear_ok     = (access_i == ACC_WRITE) && !wbit_i && state_q.marker;
        state_d.prev = sync_n_i;

        if (edge_mode_i) begin
            if (access_i == ACC_WRITE) begin
                state_d.marker = 1'b0;
            end else if (access_i == ACC_READ && state_q.flag) begin
                state_d.marker = 1'b1;
            end

            if (clear_ok) begin
                state_d.flag = 1'b0;
            end
            // a fresh edge wins over a clear in the same cycle
            if (fall) begin
                state_d.flag = 1'b1;
            end
        end else begin
            state_d.flag   = 1'b0;
            state_d.marker = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{flag: 1'b0, marker: 1'b0, prev: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign view_o = edge_mode_i ? state_q.flag : ~sync_n_i;
    assign flag_o = state_q.flag;

endmodule

// File: rtl/ext_irq_merge.sv
module ext_irq_merge #(
    parameter int NUM_PINS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] req_i,
    output logic                irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = |req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        pin_n_i,
    input  logic [5:0]        sense_edge_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              irq_o
);

    localparam int RSV_W = DATA_W - NUM_PINS;

    logic [NUM_PINS-1:0] sync_n;
    logic [NUM_PINS-1:0] view;
    logic [NUM_PINS-1:0] edge_flag_q;
    access_e             access;
    logic                unused_rsv;

    always_comb begin
        if (!bus_sel_i)    access = ACC_IDLE;
        else if (bus_wr_i) access = ACC_WRITE;
        else               access = ACC_READ;
    end

    ext_irq_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n_i  (pin_n_i),
        .sync_n_o (sync_n)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
        ext_irq_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .sync_n_i    (sync_n[i]),
            .edge_mode_i (sense_edge_i[i]),
            .access_i    (access),
            .wbit_i      (bus_wdata_i[i]),
            .view_o      (view[i]),
            .flag_o      (edge_flag_q[i])
        );
    end

    ext_irq_merge #(
        .NUM_PINS (NUM_PINS)
    ) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (view),
        .irq_o (irq_o)
    );

    assign bus_rdata_o = {{RSV_W{1'b0}}, view};
    assign unused_rsv  = ^bus_wdata_i[DATA_W-1:NUM_PINS];

endmodule

// File: rtl/ext_irq_flags_chk.sv
module ext_irq_flags_chk #(
    parameter int NUM_PINS = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] sense_edge_i,
    input logic                bus_sel_i,
    input logic                bus_wr_i,
    input logic [7:0]          bus_wdata_i,
    input logic [NUM_PINS-1:0] edge_flag_q,
    input logic                irq_o
);

    // R9: a stored edge flag raises the request on the next edge
    a_r9_irq_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_flag_q) |=> irq_o);

    // R9: a quiet request line means no edge flag was stored one cycle earlier
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> ($past(edge_flag_q) == '0));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
        // R5: an edge flag drops only after a write carrying zero in its bit
        a_r5_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(edge_flag_q[i]) && sense_edge_i[i] && $past(sense_edge_i[i]))
            |-> $past(bus_sel_i && bus_wr_i && !bus_wdata_i[i]));

        // R8: a level-mode pin never leaves a stored flag behind
        a_r8_level_no_store: assert property (@(posedge clk) disable iff (!rst_n)
            !sense_edge_i[i] |=> !edge_flag_q[i]);
    end

endmodule

bind ext_irq_flags ext_irq_flags_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sense_edge_i (sense_edge_i),
    .bus_sel_i    (bus_sel_i),
    .bus_wr_i     (bus_wr_i),
    .bus_wdata_i  (bus_wdata_i),
    .edge_flag_q  (edge_flag_q),
    .irq_o        (irq_o)
);

// File: tb/ext_irq_flags_test.sv
module ext_irq_flags_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pin_n = '1;
    logic [5:0] sense = 6'b001111;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ext_irq_flags uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_n_i      (pin_n),
        .sense_edge_i (sense),
        .bus_sel_i    (sel),
        .bus_wr_i     (wr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .irq_o        (irq)
    );

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_read(output logic [7:0] val);
        sel = 1'b1; wr = 1'b0;
        #1 val = rdata;
        tick(1);
        sel = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] val);
        sel = 1'b1; wr = 1'b1; wdata = val;
        tick(1);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic t_reset();
        check("R1 rdata", rdata, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_edge_set();
        pin_n[0] = 1'b0;
        tick(2);
        check("R10 edge not yet", rdata, 8'h00);
        tick(1);
        check("R3 R10 edge flag set", rdata, 8'h01);
        check("R9 irq still low", {7'd0, irq}, 8'h00);
        tick(1);
        check("R9 irq high", {7'd0, irq}, 8'h01);
        pin_n[0] = 1'b1;
        tick(4);
        check("R3 flag sticky", rdata, 8'h01);
    endtask

    task automatic t_write_ones();
        logic [7:0] v;
        bus_read(v);
        bus_write(8'hFF);
        check("R4 ones ignored", rdata, 8'h01);
        check("R2 reserved zero", rdata & 8'hC0, 8'h00);
    endtask

    task automatic t_clear_rule();
        logic [7:0] v;
        bus_write(8'h3E);
        check("R5 no clear without read", rdata, 8'h01);
        bus_read(v);
        check("R5 read value", v, 8'h01);
        bus_write(8'hFF);
        bus_write(8'h3E);
        check("R5 marker discarded", rdata, 8'h01);
        bus_read(v);
        bus_write(8'h3E);
        check("R5 cleared", rdata, 8'h00);
        check("R9 irq lags clear", {7'd0, irq}, 8'h01);
        tick(1);
        check("R9 irq low", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_selective_and_race();
        logic [7:0] v;
        pin_n[1] = 1'b0; pin_n[2] = 1'b0;
        tick(3);
        check("R3 two flags", rdata, 8'h06);
        bus_read(v);
        bus_write(8'h3B);
        check("R6 only bit2 cleared", rdata, 8'h02);
        // R7 staging: new edge on pin 1 meets a valid clear
        bus_read(v);
        pin_n[1] = 1'b1;
        tick(3);
        pin_n[1] = 1'b0;
        tick(2);
        bus_write(8'h3D);
        check("R7 set wins", rdata, 8'h02);
        bus_read(v);
        bus_write(8'h3D);
        check("R5 clear after race", rdata, 8'h00);
        pin_n[1] = 1'b1; pin_n[2] = 1'b1;
        tick(3);
    endtask

    task automatic t_level();
        logic [7:0] v;
        pin_n[4] = 1'b0;
        tick(1);
        check("R10 level not yet", rdata, 8'h00);
        tick(1);
        check("R8 R10 level view", rdata, 8'h10);
        tick(1);
        check("R9 irq from level", {7'd0, irq}, 8'h01);
        bus_read(v);
        bus_write(8'h00);
        check("R8 write ignored", rdata, 8'h10);
        pin_n[4] = 1'b1;
        tick(2);
        check("R8 level released", rdata, 8'h00);
        tick(1);
        check("R9 irq released", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        tick(2);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_edge_set();
        t_write_ones();
        t_clear_rule();
        t_selective_and_race();
        t_level();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule